// File: doc/BRIEF.md
# Partitionable Mixed-Sign Multiplier Array

This block is a two-stage pipelined multiplier whose single datapath can be split at run time in three ways: eight independent 9-bit by 9-bit products, four 18-bit by 18-bit products, or one 36-bit by 36-bit product. Two run-time controls choose separately whether operand A and operand B are two's-complement or unsigned. The same pair of controls applies to every lane at once. Every product is delivered at full precision (2N bits for an N-bit lane), together with a valid flag.

The operand registers load in one of two ways. In parallel mode every lane takes its own field of the input bus. In chain mode, operand A moves along from lane to lane, so the array behaves as the tap delay line of a FIR filter while operand B still loads in parallel. Operands narrower than a lane are placed in the smallest mode that holds them: up to 9 bits in the 9-bit mode, 10 to 18 bits in the 18-bit mode, and 19 to 36 bits in the 36-bit mode. The mode must stay fixed while valid samples are still in the pipeline.

Top module: `pmul_array`

## Requirements
- R1: With `mode` = 2'b00, lane i (i = 0..7) multiplies `a_in[9i+8:9i]` by `b_in[9i+8:9i]`, and its 18-bit product appears on `out_prod[18i+17:18i]`.
- R2: With `mode` = 2'b01, lane j (j = 0..3) multiplies `a_in[18j+17:18j]` by `b_in[18j+17:18j]`, and its 36-bit product appears on `out_prod[36j+35:36j]`.
- R3: With `mode` = 2'b10 (2'b11 acts the same), `a_in[35:0]` is multiplied by `b_in[35:0]`. The 72-bit product appears on `out_prod[71:0]` and `out_prod[143:72]` is zero.
- R4: `sign_a` = 1 makes each A field two's-complement (sign-extended), and 0 makes it unsigned (zero-extended). `sign_b` does the same for B. Both controls apply to all lanes. Each product equals the exact mathematical product, taken modulo 2^(2N), and this includes the mixed-sign cases.
- R5: When a sample is presented with `in_valid` high at a rising edge, its product and `out_valid` = 1 appear after the second rising edge. When `in_valid` is low, `out_valid` is low two edges later.
- R6: With `shift_en` = 1 in the 9-bit or 18-bit mode, each accepted sample moves the registered A of lane k into lane k+1. Lane 0 takes the lowest A field of `a_in`, and B still loads in parallel.
- R7: In the 36-bit mode, `shift_en` has no effect and A loads in parallel.
- R8: The sign controls, the mode and the operands are captured with the sample. Changing `sign_a` or `sign_b` after the sample edge does not alter that sample's product.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_prod` and the operand registers, so that a chain that starts after reset shifts in from zero.
- R10: While no new sample is moving through the pipeline, `out_prod` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on the operand buses |
| mode | input | 2 | Partition: 00 = 8 lanes of 9 bits, 01 = 4 lanes of 18 bits, 10/11 = one 36-bit lane |
| shift_en | input | 1 | 1 = A moves along the lane chain, 0 = parallel load |
| sign_a | input | 1 | 1 = operand A is two's-complement |
| sign_b | input | 1 | 1 = operand B is two's-complement |
| a_in | input | 72 | Operand A fields |
| b_in | input | 72 | Operand B fields |
| out_valid | output | 1 | Product bus holds a new result |
| out_prod | output | 144 | Full-precision products |

## Verification
Two things can happen in the same cycle. A new sample shifts the A chain forward in the input stage while the product of the previous chain state is being registered at the output. If the chain advanced one edge too early, that product would be formed from the wrong taps. The bench provokes this by feeding chain-mode samples back to back, with and without gaps. A behavioural model, built from a tap array and a product function, is compared against the outputs on every cycle. A second collision occurs when the sign controls flip in the cycle right after a sample edge. The model keeps the signs that were captured with the sample, so any leak of the new signs into that product is reported.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    localparam int PM_LANES = 8;

    typedef enum logic [1:0] {
        PM_NINE     = 2'b00,
        PM_EIGHTEEN = 2'b01,
        PM_WIDE     = 2'b10,
        PM_WIDE_ALT = 2'b11
    } pmul_mode_e;

endpackage

// File: rtl/pmul_in_stage.sv
module pmul_in_stage
    import pmul_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic                         shift_en,
    input  logic [1:0]                   mode,
    input  logic                         sign_a,
    input  logic                         sign_b,
    input  logic [LANE_W*PM_LANES-1:0]   a_in,
    input  logic [LANE_W*PM_LANES-1:0]   b_in,
    output logic                         s1_valid,
    output pmul_mode_e                   s1_mode,
    output logic                         s1_sa,
    output logic                         s1_sb,
    output logic [LANE_W*PM_LANES-1:0]   s1_a,
    output logic [LANE_W*PM_LANES-1:0]   s1_b
);

    localparam int DW = LANE_W * PM_LANES;
    localparam int MW = 2 * LANE_W;

    pmul_mode_e mode_e;
    logic [DW-1:0] a_nxt;

    assign mode_e = pmul_mode_e'(mode);

    // Next A value: chain shift by one lane width, or parallel load
    always_comb begin
        unique case (mode_e)
            PM_NINE:     a_nxt = shift_en ? {s1_a[DW-LANE_W-1:0], a_in[LANE_W-1:0]} : a_in;
            PM_EIGHTEEN: a_nxt = shift_en ? {s1_a[DW-MW-1:0], a_in[MW-1:0]} : a_in;
            default:     a_nxt = a_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_mode  <= PM_NINE;
            s1_sa    <= 1'b0;
            s1_sb    <= 1'b0;
            s1_a     <= '0;
            s1_b     <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_mode <= mode_e;
                s1_sa   <= sign_a;
                s1_sb   <= sign_b;
                s1_a    <= a_nxt;
                s1_b    <= b_in;
            end
        end
    end

    AST_CHAIN_NINE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shift_en && mode_e == PM_NINE) |=> s1_a[MW-1:LANE_W] == $past(s1_a[LANE_W-1:0])); // R6
    AST_WIDE_PARALLEL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode[1]) |=> s1_a == $past(a_in)); // R7

endmodule

// File: rtl/pmul_lane.sv
module pmul_lane #(
    parameter int W = 9
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sa,
    input  logic           sb,
    output logic [2*W-1:0] p
);

    logic signed [W:0]     ea;
    logic signed [W:0]     eb;
    logic signed [2*W+1:0] full;

    always_comb begin
        ea   = $signed({sa & a[W-1], a});
        eb   = $signed({sb & b[W-1], b});
        full = ea * eb;
        p    = full[2*W-1:0];
    end

    always_comb begin
        if (a == '0 || b == '0) begin
            AST_LANE_ZERO: assert (p == '0); // R4
        end
    end

endmodule

// File: rtl/pmul_prod_stage.sv
module pmul_prod_stage
    import pmul_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           s1_valid,
    input  pmul_mode_e                     s1_mode,
    input  logic                           mul_sa,
    input  logic                           mul_sb,
    input  logic [LANE_W*PM_LANES-1:0]     s1_a,
    input  logic [LANE_W*PM_LANES-1:0]     s1_b,
    output logic                           out_valid,
    output logic [2*LANE_W*PM_LANES-1:0]   out_prod
);

    localparam int DW    = LANE_W * PM_LANES;
    localparam int PW    = 2 * DW;
    localparam int MW    = 2 * LANE_W;
    localparam int WW    = 4 * LANE_W;
    localparam int MIDS  = PM_LANES / 2;

    logic          is_wide;
    logic [PW-1:0] cat9;
    logic [PW-1:0] cat18;
    logic [DW-1:0] wide_sum;
    logic [PW-1:0] prod_nxt;

    logic [2*MW-1:0] p18 [MIDS];
    logic            psg [MIDS];
    logic [DW-1:0]   pext [MIDS];

    assign is_wide = s1_mode[1];

    // Eight narrow lanes
    for (genvar g = 0; g < PM_LANES; g++) begin : g_nine
        logic [MW-1:0] pn;
        pmul_lane #(.W(LANE_W)) u_lane (
            .a  (s1_a[g*LANE_W +: LANE_W]),
            .b  (s1_b[g*LANE_W +: LANE_W]),
            .sa (mul_sa),
            .sb (mul_sb),
            .p  (pn)
        );
        assign cat9[g*MW +: MW] = pn;
    end

    // Four mid lanes, reused as partial-product units in the wide mode
    for (genvar g = 0; g < MIDS; g++) begin : g_mid
        localparam bit HI_A = (g >= 2);
        localparam bit HI_B = ((g % 2) == 1);
        logic [MW-1:0]   ua;
        logic [MW-1:0]   ub;
        logic            usa;
        logic            usb;
        logic [2*MW-1:0] up;

        always_comb begin
            if (is_wide) begin
                ua  = HI_A ? s1_a[WW-1:MW] : s1_a[MW-1:0];
                ub  = HI_B ? s1_b[WW-1:MW] : s1_b[MW-1:0];
                usa = HI_A ? mul_sa : 1'b0;
                usb = HI_B ? mul_sb : 1'b0;
            end else begin
                ua  = s1_a[g*MW +: MW];
                ub  = s1_b[g*MW +: MW];
                usa = mul_sa;
                usb = mul_sb;
            end
        end

        pmul_lane #(.W(MW)) u_lane (
            .a  (ua),
            .b  (ub),
            .sa (usa),
            .sb (usb),
            .p  (up)
        );

        assign p18[g]  = up;
        assign psg[g]  = usa | usb;
        assign pext[g] = {{(DW-2*MW){psg[g] & up[2*MW-1]}}, up};
        assign cat18[g*2*MW +: 2*MW] = up;
    end

    // Wide product: low*low + (low*high + high*low) << MW + high*high << 2MW
    always_comb begin
        wide_sum = pext[0]
                 + (pext[1] << MW)
                 + (pext[2] << MW)
                 + (pext[3] << (2*MW));
    end

    always_comb begin
        unique case (s1_mode)
            PM_NINE:     prod_nxt = cat9;
            PM_EIGHTEEN: prod_nxt = cat18;
            default:     prod_nxt = {{(PW-DW){1'b0}}, wide_sum};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_prod  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_prod <= prod_nxt;
            end
        end
    end

    AST_WIDE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && is_wide) |=> out_prod[PW-1:DW] == '0); // R3
    AST_WIDE_SQUARE_POS: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && is_wide && mul_sa && mul_sb && s1_a[WW-1:0] == s1_b[WW-1:0])
        |=> !out_prod[2*WW-1]); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(out_prod)); // R10

endmodule

// File: rtl/pmul_array.sv
module pmul_array
    import pmul_pkg::*;
#(
    parameter int LANE_W        = 9,
    parameter bit SIGN_AT_INPUT = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [1:0]                    mode,
    input  logic                          shift_en,
    input  logic                          sign_a,
    input  logic                          sign_b,
    input  logic [LANE_W*8-1:0]           a_in,
    input  logic [LANE_W*8-1:0]           b_in,
    output logic                          out_valid,
    output logic [LANE_W*16-1:0]          out_prod
);

    localparam int DW = LANE_W * PM_LANES;

    logic          s1_valid;
    pmul_mode_e    s1_mode;
    logic          s1_sa;
    logic          s1_sb;
    logic [DW-1:0] s1_a;
    logic [DW-1:0] s1_b;
    logic          mul_sa;
    logic          mul_sb;

    pmul_in_stage #(.LANE_W(LANE_W)) u_in (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .shift_en (shift_en),
        .mode     (mode),
        .sign_a   (sign_a),
        .sign_b   (sign_b),
        .a_in     (a_in),
        .b_in     (b_in),
        .s1_valid (s1_valid),
        .s1_mode  (s1_mode),
        .s1_sa    (s1_sa),
        .s1_sb    (s1_sb),
        .s1_a     (s1_a),
        .s1_b     (s1_b)
    );

    // Sign controls either travel with the sample or arrive one stage later
    if (SIGN_AT_INPUT) begin : g_sign_reg
        assign mul_sa = s1_sa;
        assign mul_sb = s1_sb;
    end else begin : g_sign_late
        assign mul_sa = sign_a;
        assign mul_sb = sign_b;
    end

    pmul_prod_stage #(.LANE_W(LANE_W)) u_prod (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_mode   (s1_mode),
        .mul_sa    (mul_sa),
        .mul_sb    (mul_sb),
        .s1_a      (s1_a),
        .s1_b      (s1_b),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    AST_LATENCY_HIGH: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid); // R5
    AST_LATENCY_LOW: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_prod == '0)); // R9

endmodule

// File: tb/pmul_array_tb.sv
module pmul_array_tb;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         shift_en = 1'b0;
    logic         sign_a = 1'b0;
    logic         sign_b = 1'b0;
    logic [71:0]  a_in = '0;
    logic [71:0]  b_in = '0;
    logic         out_valid;
    logic [143:0] out_prod;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R9";
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmul_array u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mode      (mode),
        .shift_en  (shift_en),
        .sign_a    (sign_a),
        .sign_b    (sign_b),
        .a_in      (a_in),
        .b_in      (b_in),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    // Exact product per lane, from the arithmetic definition
    function automatic logic [143:0] ref_prod(logic [1:0] md, logic [71:0] a, logic [71:0] b,
                                              bit sa, bit sb);
        int w;
        int n;
        logic [143:0] r;
        r = '0;
        if (md == 2'b00) begin w = 9; n = 8; end
        else if (md == 2'b01) begin w = 18; n = 4; end
        else begin w = 36; n = 1; end
        for (int i = 0; i < n; i++) begin
            logic [71:0] fa;
            logic [71:0] fb;
            logic [74:0] ea;
            logic [74:0] eb;
            logic [74:0] pr;
            fa = (a >> (w*i)) & ((72'd1 << w) - 72'd1);
            fb = (b >> (w*i)) & ((72'd1 << w) - 72'd1);
            ea = {3'b000, fa};
            eb = {3'b000, fb};
            if (sa && fa[w-1]) ea = ea - (75'd1 << w);
            if (sb && fb[w-1]) eb = eb - (75'd1 << w);
            pr = 75'($signed(ea) * $signed(eb));
            r = r | (((144'(pr[71:0])) & ((144'd1 << (2*w)) - 144'd1)) << (2*w*i));
        end
        return r;
    endfunction

    // Cycle-level reference model
    logic [71:0]  m_taps;
    logic [71:0]  m_b;
    logic [1:0]   m_mode;
    bit           m_sa, m_sb, m_v1, m_ov;
    logic [143:0] m_out;

    always @(posedge clk) begin
        if (rst) begin
            m_taps <= '0; m_b <= '0; m_mode <= 2'b00;
            m_sa <= 1'b0; m_sb <= 1'b0; m_v1 <= 1'b0; m_ov <= 1'b0; m_out <= '0;
        end else begin
            m_ov <= m_v1;
            if (m_v1) m_out <= ref_prod(m_mode, m_taps, m_b, m_sa, m_sb);
            m_v1 <= in_valid;
            if (in_valid) begin
                m_mode <= mode; m_sa <= sign_a; m_sb <= sign_b; m_b <= b_in;
                if (shift_en && mode == 2'b00)      m_taps <= {m_taps[62:0], a_in[8:0]};
                else if (shift_en && mode == 2'b01) m_taps <= {m_taps[53:0], a_in[17:0]};
                else                                m_taps <= a_in;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (out_valid !== m_ov || out_prod !== m_out) begin
                fails++;
                $display("FAIL %s cycle compare: valid=%0b prod=%h expected valid=%0b prod=%h",
                         cur_req, out_valid, out_prod, m_ov, m_out);
            end
        end
    end

    task automatic check_val(string req, logic [143:0] exp_p, bit exp_v);
        checks++;
        if (out_prod !== exp_p || out_valid !== exp_v) begin
            fails++;
            $display("FAIL %s explicit: valid=%0b prod=%h expected valid=%0b prod=%h",
                     req, out_valid, out_prod, exp_v, exp_p);
        end
    endtask

    task automatic send(logic [1:0] md, bit sh, bit sa, bit sb, logic [71:0] a, logic [71:0] b);
        @(negedge clk);
        in_valid = 1'b1; mode = md; shift_en = sh; sign_a = sa; sign_b = sb; a_in = a; b_in = b;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic logic [71:0] rnd72();
        return {$urandom, $urandom, $urandom};
    endfunction

    task automatic burst(logic [1:0] md, bit sh, int n);
        for (int i = 0; i < n; i++) begin
            send(md, sh, i[0], i[1], rnd72(), rnd72());
        end
        idle(3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check_val("R9", '0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R1: eight narrow lanes, all sign combinations
        cur_req = "R1";
        burst(2'b00, 1'b0, 16);
        // R4: narrow lane corners, -256 x -256 and -1 x 255 (unsigned B)
        cur_req = "R4";
        send(2'b00, 1'b0, 1'b1, 1'b1, {8{9'h100}}, {8{9'h100}});
        send(2'b00, 1'b0, 1'b1, 1'b0, {8{9'h1FF}}, {8{9'h0FF}});
        idle(3);

        // R2: four mid lanes
        cur_req = "R2";
        burst(2'b01, 1'b0, 16);

        // R3: one wide lane, upper half zero
        cur_req = "R3";
        burst(2'b10, 1'b0, 12);
        burst(2'b11, 1'b0, 4);

        // R4: wide mixed sign, -1 (signed) x 3 (unsigned) = -3 in 72 bits
        cur_req = "R4";
        send(2'b10, 1'b0, 1'b1, 1'b0, {36'd0, 36'hFFFFFFFFF}, {36'd0, 36'd3});
        idle(1);
        @(negedge clk);
        check_val("R4", {72'd0, {70{1'b1}}, 2'b01}, 1'b1);
        // unsigned max x unsigned max, and most negative squared
        send(2'b10, 1'b0, 1'b0, 1'b0, {36'd0, 36'hFFFFFFFFF}, {36'd0, 36'hFFFFFFFFF});
        send(2'b10, 1'b0, 1'b1, 1'b1, {36'd0, 36'h800000000}, {36'd0, 36'h800000000});
        idle(1);
        @(negedge clk);
        check_val("R4", {72'd0, 72'h400000000000000000}, 1'b1);
        idle(2);

        // R5: single sample latency, then no valid after idle
        cur_req = "R5";
        send(2'b00, 1'b0, 1'b0, 1'b0, {8{9'd3}}, {8{9'd5}});
        idle(1);
        check_val("R5", '0 | ref_prod(2'b10, {36'd0, 36'h800000000}, {36'd0, 36'h800000000}, 1'b1, 1'b1), 1'b0);
        @(negedge clk);
        check_val("R5", {8{18'd15}}, 1'b1);
        @(negedge clk);
        check_val("R10", {8{18'd15}}, 1'b0);
        idle(2);

        // R6: chain in narrow and mid modes, back to back and with gaps
        cur_req = "R6";
        burst(2'b00, 1'b1, 12);
        for (int i = 0; i < 6; i++) begin
            send(2'b01, 1'b1, 1'b1, 1'b0, rnd72(), rnd72());
            if (i[0]) idle(1);
        end
        idle(3);

        // R7: shift request ignored in the wide mode
        cur_req = "R7";
        burst(2'b10, 1'b1, 6);

        // R8: signs flip right after the sample edge
        cur_req = "R8";
        for (int i = 0; i < 4; i++) begin
            send(2'b01, 1'b0, 1'b1, 1'b1, rnd72(), rnd72());
            @(negedge clk);
            in_valid = 1'b0; sign_a = 1'b0; sign_b = 1'b0;
        end
        idle(3);

        // R10: long idle with signs and operands toggling
        cur_req = "R10";
        send(2'b00, 1'b0, 1'b1, 1'b0, rnd72(), rnd72());
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b0; a_in = rnd72(); b_in = rnd72(); sign_a = i[0];
        end

        // R9: reset in mid-stream, then chain restarts from zero taps
        cur_req = "R9";
        send(2'b00, 1'b1, 1'b0, 1'b0, rnd72(), rnd72());
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_val("R9", '0, 1'b0);
        send(2'b00, 1'b1, 1'b0, 1'b0, 72'd7, {8{9'd2}});
        idle(1);
        @(negedge clk);
        check_val("R9", {126'd0, 18'd14}, 1'b1);
        idle(3);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule